// File: doc/BRIEF.md
# Stall-Priority Two-Thread Scheduler

This block decides which of two software threads a shared, time-multiplexed core runs next. Each thread also runs on its own partner core, and a flag per thread says whether that partner core is stalled. A thread whose partner core is stalled is picked first, so the shared core can catch up on it. When both flags or neither flag is set, the block keeps the running thread to avoid the cost of a context switch. A run-length cap stops one thread from holding the core forever.

A decision happens only in a cycle where the strobe is high. The block keeps the current thread and a saturating count of how many decisions in a row chose it. Both are updated at the clock edge that ends the strobe cycle. The selected thread is a registered output. A one-cycle switch pulse marks every decision that changed the thread. Saving and restoring thread context is left to the surrounding logic.

Top module: `stallprio_sched`

## Requirements
- R1: After reset the selected thread is 0, the switch output is 0 and the run count is 0, so with neither flag set and a cap of 1 the first decision keeps thread 0.
- R2: A decision with stall_i = 2'b01 (bit 0 is thread 0's flag) selects thread 0.
- R3: A decision with stall_i = 2'b10 (bit 1 is thread 1's flag) selects thread 1.
- R4: A decision with stall_i = 2'b11 selects the thread that was already selected.
- R5: A decision with stall_i = 2'b00 keeps the current thread when the run count is below run_cap_i, and otherwise selects the other thread.
- R6: Every decision updates the run count. The count becomes 1 when the chosen thread differs from the previous one, and goes up by one when the same thread is chosen again. With stall_i = 2'b00 and a cap of N ≥ 1, each thread therefore holds the core for N decisions in a row.
- R7: The run count saturates at 2^CNT_W-1 and does not wrap. With the cap at that value, a long run under stall_i = 2'b11 followed by a stall_i = 2'b00 decision forces a switch.
- R8: In cycles with decide_i low, sel_o holds its value and switch_o is 0, whatever stall_i and run_cap_i do.
- R9: switch_o is 1 for exactly the cycle after a decision that changed the thread, and is 0 after a decision that kept it.
- R10: With run_cap_i = 0, every stall_i = 2'b00 decision switches thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decide_i | input | 1 | Decision strobe, one cycle per decision |
| stall_i | input | 2 | Partner-core stall flags; bit n belongs to thread n |
| run_cap_i | input | CNT_W | Maximum consecutive selections when no flag is set |
| sel_o | output | 1 | Selected thread index |
| switch_o | output | 1 | One-cycle pulse after a decision that changed thread |

## Verification
The sweeps use caps from 0 to 5. Each cap gets a scrambled sequence of all four flag patterns, with a bias toward the unstalled case. The single-flag patterns show that priority wins over the running thread. The both-set pattern shows that the thread is kept while the run count still moves. The clear pattern shows the cap comparison and the run-count restart after a switch. A long both-set run at the top cap separates a saturating counter from a wrapping one. Idle cycles with changing flags show that inputs outside the strobe are ignored.

// File: rtl/stallprio_pkg.sv
package stallprio_pkg;
  typedef enum logic {
    THR0 = 1'b0,
    THR1 = 1'b1
  } thr_e;
endpackage

// File: rtl/stallprio_pick.sv
module stallprio_pick
  import stallprio_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [1:0]       stall,
  input  thr_e             cur,
  input  logic [CNT_W-1:0] run_len,
  input  logic [CNT_W-1:0] cap,
  output thr_e             nxt
);
  // Stalled threads win; a tie or no stall keeps the runner until the cap.
  always_comb begin
    unique case (stall)
      2'b11:   nxt = cur;
      2'b01:   nxt = THR0;
      2'b10:   nxt = THR1;
      default: nxt = (run_len < cap) ? cur : thr_e'(~cur);
    endcase
  end
endmodule

// File: rtl/stallprio_runlen.sv
module stallprio_runlen #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  output logic [CNT_W-1:0] len
);
  localparam logic [CNT_W-1:0] LEN_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LEN_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] len_d;

  always_comb begin
    len_d = len;
    if (en) begin
      if (restart)              len_d = LEN_ONE;
      else if (len != LEN_MAX)  len_d = len + LEN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  len <= '0;
    else if (en) len <= len_d;
  end
endmodule

// File: rtl/stallprio_sched.sv
module stallprio_sched
  import stallprio_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decide_i,
  input  logic [1:0]       stall_i,
  input  logic [CNT_W-1:0] run_cap_i,
  output logic             sel_o,
  output logic             switch_o
);
  thr_e             cur_q, cur_d, pick;
  logic             sw_d, sw_q, changed;
  logic [CNT_W-1:0] run_len;

  stallprio_pick #(.CNT_W(CNT_W)) pick_i (
    .stall   (stall_i),
    .cur     (cur_q),
    .run_len (run_len),
    .cap     (run_cap_i),
    .nxt     (pick)
  );

  assign changed = (pick != cur_q);

  stallprio_runlen #(.CNT_W(CNT_W)) runlen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (decide_i),
    .restart (changed),
    .len     (run_len)
  );

  always_comb begin
    cur_d = decide_i ? pick : cur_q;
    sw_d  = decide_i & changed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= THR0;
      sw_q  <= 1'b0;
    end else begin
      cur_q <= cur_d;
      sw_q  <= sw_d;
    end
  end

  assign sel_o    = cur_q;
  assign switch_o = sw_q;
endmodule

// File: rtl/stallprio_sched_chk.sv
module stallprio_sched_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             decide,
  input logic [1:0]       stall,
  input logic [CNT_W-1:0] cap,
  input logic             sel,
  input logic             sw,
  input logic [CNT_W-1:0] len
);
  assert_only0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    decide && stall == 2'b01 |=> sel == 1'b0);
  assert_only1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    decide && stall == 2'b10 |=> sel == 1'b1);
  assert_both_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    decide && stall == 2'b11 |=> $stable(sel));
  assert_cap_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    decide && stall == 2'b00 && len >= cap |=> sel != $past(sel));
  assert_under_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    decide && stall == 2'b00 && len < cap |=> $stable(sel));
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw |-> len == 1);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> $stable(sel) && !sw && $stable(len));
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> sw == (sel != $past(sel)));
endmodule

bind stallprio_sched stallprio_sched_chk #(.CNT_W(CNT_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .decide (decide_i),
  .stall  (stall_i),
  .cap    (run_cap_i),
  .sel    (sel_o),
  .sw     (switch_o),
  .len    (run_len)
);

// File: tb/stallprio_sched_tb_top.sv
module stallprio_sched_tb_top;
  localparam int CNT_W = 4;
  localparam int LMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             decide = 1'b0;
  logic [1:0]       stall = 2'b00;
  logic [CNT_W-1:0] cap = '0;
  logic             sel, sw;

  int n_chk = 0, n_fail = 0;
  int m_cur, m_len;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  stallprio_sched #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .decide_i(decide), .stall_i(stall),
    .run_cap_i(cap), .sel_o(sel), .switch_o(sw)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; decide = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_cur = 0; m_len = 0;
    @(negedge clk);
  endtask

  function automatic logic [1:0] rnd2();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[1:0];
  endfunction

  // One decision, then one idle cycle with scrambled flags.
  task automatic step(input logic [1:0] st, input string tag);
    int nxt, exp_sw, old;
    stall = st; decide = 1'b1;
    case (st)
      2'b11: nxt = m_cur;
      2'b01: nxt = 0;
      2'b10: nxt = 1;
      default: nxt = (m_len < int'(cap)) ? m_cur : 1 - m_cur;
    endcase
    exp_sw = (nxt != m_cur);
    m_len = exp_sw ? 1 : ((m_len == LMAX) ? LMAX : m_len + 1);
    m_cur = nxt;
    @(negedge clk);
    decide = 1'b0; stall = rnd2();
    chk(tag, sel, m_cur);
    chk("R9 switch pulse", sw, exp_sw);
    old = sel;
    @(negedge clk);
    chk("R8 idle hold sel", sel, old);
    chk("R8 idle no pulse", sw, 0);
  endtask

  function automatic string tag_of(input logic [1:0] st);
    case (st)
      2'b11: return "R4 both stalled";
      2'b01: return "R2 thread0 stalled";
      2'b10: return "R3 thread1 stalled";
      default: return "R5 R6 R10 unstalled cap";
    endcase
  endfunction

  initial begin
    do_reset();
    chk("R1 reset sel", sel, 0);
    chk("R1 reset switch", sw, 0);
    cap = 4'd1;
    step(2'b00, "R1 first decision keeps thread 0");
    step(2'b00, "R6 cap 1 forces switch");

    // R6: cap 3 gives three selections per thread.
    do_reset();
    cap = 4'd3;
    for (int i = 0; i < 9; i++)
      step(2'b00, "R6 run of cap length");

    // R10: cap 0 switches on every unstalled decision.
    do_reset();
    cap = 4'd0;
    for (int i = 0; i < 4; i++) step(2'b00, "R10 cap zero");

    // Sweeps over caps and scrambled flag patterns.
    for (int c = 0; c <= 5; c++) begin
      do_reset();
      cap = c[CNT_W-1:0];
      for (int i = 0; i < 60; i++) begin
        logic [1:0] st;
        st = rnd2();
        if (st == 2'b11 && lfsr[5]) st = 2'b00;
        step(st, tag_of(st));
      end
    end

    // R7: saturation at the top cap.
    do_reset();
    cap = 4'(LMAX);
    for (int i = 0; i < LMAX + 6; i++) step(2'b11, "R7 R4 long both-stalled run");
    step(2'b00, "R7 saturated count forces switch");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule